// File: doc/BRIEF.md
# External Interrupt Unit with Pin Noise Filter

The block watches four external interrupt pins and turns the trigger condition programmed for each one into a pending request. Each pin passes through a two-flop synchronizer. Pin 3 also passes through a digital noise filter. That filter samples at 1/1, 1/16 or 1/64 of the instruction clock and takes a new level only after two samples in a row agree. The clock of the block is the instruction clock.

Pins 0 and 1 can trigger on a rising edge, a falling edge, a high level or a low level. Pins 2 and 3 can trigger on a rising edge, a falling edge or both edges. An edge event sets a sticky flag, which stays set until a clear strobe removes it. A level trigger asserts the request for as long as the level lasts. A mode a pin does not support leaves that pin silent.

The enabled requests are ranked with pin 0 highest and pin 3 lowest. The unit reports the winner as a request line plus a vector address, given by 0x03 + 8 × pin.

Top module: `ext_irq_unit`

## Requirements
- R1: Trigger code 1 (rising) sets a pin's pending flag after a 0→1 pin change, and code 2 (falling) sets it after a 1→0 change. The flag stays set after the pin returns, until a `clr_i` strobe for that pin. This holds on all four pins.
- R2: Trigger code 3 (both edges) sets the flag on either edge for pins 2 and 3.
- R3: On pins 0 and 1, code 4 (high level) makes the pin pending while the pin is 1, and code 5 (low level) while it is 0. A clear strobe does not remove a level request while the level persists.
- R4: Code 0, codes 6 to 15, code 3 on pins 0/1 and codes 4/5 on pins 2/3 never make the pin pending.
- R5: Writing address 0 (pin 0 mode in data[3:0], pin 1 mode in data[7:4]) or address 1 (pins 2 and 3 in the same layout) clears the edge flags of the two pins that the write covers.
- R6: Address 2 data[3:0] is the per-pin enable. `irq_req_o` is 1 only when some enabled pin is pending. With no request, `irq_vec_o` is 0.
- R7: Among the enabled pending pins, the lowest index wins, and `irq_vec_o` is 0x03, 0x0B, 0x13 or 0x1B for pins 0 to 3.
- R8: A `clr_i` bit clears only the edge flag of its own pin.
- R9: Address 3 data[1:0] selects the pin 3 filter rate: 0 is 1/1, 1 is 1/16, and 2 or 3 is 1/64. At 1/1, a one-cycle pulse on pin 3 is rejected and a two-cycle pulse is accepted.
- R10: At 1/16, a 12-cycle pulse is rejected and a 40-cycle pulse is accepted. At 1/64, a 48-cycle pulse is rejected and a 140-cycle pulse is accepted.
- R11: Pins 0, 1 and 2 accept a pulse one instruction cycle wide.
- R12: After reset, all modes are 0, all enables are 0 and the filter rate is 1/1, so nothing is pending, `irq_req_o` is 0 and `irq_vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | External interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| clr_i | input | 4 | Per-pin edge flag clear strobes |
| pend_o | output | 4 | Per-pin pending state |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector address of the winning request |

## Verification
Every pin is swept through all sixteen trigger codes with the same stimulus: a rise, a clear, a fall and a clear. That separates edge flags that stick from level requests that follow the pin, and it shows each illegal code as a pin that never becomes pending. A sweep over all sixteen enable masks with every pin pending tells the priority order and the vectors apart. Pin 3 pulses just below and just above each filter window separate the three sampling rates. One-cycle pulses on the other pins confirm they have no filter. Single-pin clears and mode rewrites show which flags each action touches.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [3:0] {
    TRIG_OFF  = 4'd0,
    TRIG_RISE = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_BOTH = 4'd3,
    TRIG_HIGH = 4'd4,
    TRIG_LOW  = 4'd5
  } trig_e;

  typedef enum logic [1:0] {
    REG_MODE_LO = 2'd0,
    REG_MODE_HI = 2'd1,
    REG_ENABLE  = 2'd2,
    REG_FILTER  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter #(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       d_i,
  output logic       q_o
);
  localparam int CW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [CW-1:0] cnt_q, reload;
  logic          tick, samp_q, filt_q;

  always_comb begin
    case (sel_i)
      2'd0:    reload = '0;
      2'd1:    reload = CW'(DIV_MID - 1);
      default: reload = CW'(DIV_SLOW - 1);
    endcase
  end

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      samp_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      cnt_q <= tick ? reload : cnt_q - 1'b1;
      if (tick) begin
        samp_q <= d_i;
        // accept only when two consecutive samples agree
        if (d_i == samp_q) filt_q <= d_i;
      end
    end
  end

  assign q_o = filt_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter bit ALLOW_LEVEL = 1'b1,
  parameter bit ALLOW_BOTH  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [3:0] mode_i,
  input  logic       mode_wr_i,
  input  logic       clr_i,
  output logic       pend_o
);
  trig_e mode;
  logic  prev_q, flag_q, rise, fall, evt, lvl_hit;

  assign mode = trig_e'(mode_i);
  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    evt     = 1'b0;
    lvl_hit = 1'b0;
    case (mode)
      TRIG_RISE: evt = rise;
      TRIG_FALL: evt = fall;
      TRIG_BOTH: evt = ALLOW_BOTH & (rise | fall);
      TRIG_HIGH: lvl_hit = ALLOW_LEVEL & lvl_i;
      TRIG_LOW:  lvl_hit = ALLOW_LEVEL & ~lvl_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (mode_wr_i)  flag_q <= 1'b0;
      else if (evt)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign pend_o = flag_q | lvl_hit;
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int       N         = 4,
  parameter int       VW        = 8,
  parameter int       VEC_FIRST = 3,
  parameter int       VEC_STEP  = 8
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    any_o = |req_i;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VW'(VEC_FIRST + VEC_STEP * i);
    end
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] pin_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] clr_i,
  output logic [3:0] pend_o,
  output logic       irq_req_o,
  output logic [7:0] irq_vec_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0][3:0] mode_q;
  logic [NPIN-1:0]      en_q;
  logic [1:0]           fsel_q;
  logic [NPIN-1:0]      pin_s, cond, pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
      fsel_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        REG_MODE_LO: begin mode_q[0] <= wr_data_i[3:0]; mode_q[1] <= wr_data_i[7:4]; end
        REG_MODE_HI: begin mode_q[2] <= wr_data_i[3:0]; mode_q[3] <= wr_data_i[7:4]; end
        REG_ENABLE:  en_q   <= wr_data_i[NPIN-1:0];
        REG_FILTER:  fsel_q <= wr_data_i[1:0];
        default: ;
      endcase
    end
  end

  ext_irq_sync #(.WIDTH(NPIN)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  ext_irq_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) i_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (fsel_q),
    .d_i   (pin_s[NPIN-1]),
    .q_o   (cond[NPIN-1])
  );
  assign cond[NPIN-2:0] = pin_s[NPIN-2:0];

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    ext_irq_detect #(
      .ALLOW_LEVEL(g < 2),
      .ALLOW_BOTH (g >= 2)
    ) i_detect (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_i    (cond[g]),
      .mode_i   (mode_q[g]),
      .mode_wr_i(wr_en_i && (wr_addr_i == 2'(g / 2))),
      .clr_i    (clr_i[g]),
      .pend_o   (pend[g])
    );
  end

  ext_irq_prio #(.N(NPIN), .VW(8), .VEC_FIRST(3), .VEC_STEP(8)) i_prio (
    .req_i(pend & en_q),
    .any_o(irq_req_o),
    .vec_o(irq_vec_o)
  );

  assign pend_o = pend;
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_req_o,
  input logic [7:0]      irq_vec_o,
  input logic [3:0]      pend_o,
  input logic [3:0]      en_q,
  input logic [3:0][3:0] mode_q,
  input logic            filt_in,
  input logic            filt_out
);
  AST_VEC_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_vec_o[2:0] == 3'b011); // R7

  AST_IDLE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> irq_vec_o == 8'h00); // R6

  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> |(pend_o & en_q)); // R6

  AST_TOP_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[0] && en_q[0]) |-> irq_vec_o == 8'h03); // R7

  AST_PIN2_LEVEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[2] == 4'd4 || mode_q[2] == 4'd5 || mode_q[2] > 4'd5) |-> !pend_o[2]); // R4

  AST_PIN0_BOTH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[0] == 4'd3 || mode_q[0] == 4'd0) |-> !pend_o[0]); // R4

  AST_FILT_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_out != $past(filt_out)) |-> ($past(filt_in) == filt_out)); // R9
endmodule

bind ext_irq_unit ext_irq_unit_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o),
  .pend_o   (pend_o),
  .en_q     (en_q),
  .mode_q   (mode_q),
  .filt_in  (pin_s[3]),
  .filt_out (cond[3])
);

// File: tb/test_ext_irq_unit.sv
module test_ext_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] clr = '0;
  logic [3:0] pend;
  logic       req;
  logic [7:0] vec;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ext_irq_unit i_ext_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .clr_i(clr),
    .pend_o(pend), .irq_req_o(req), .irq_vec_o(vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] c);
    @(negedge clk);
    clr = c;
    @(negedge clk);
    clr = '0;
  endtask

  function automatic bit legal(input int p, input int m);
    if (m == 1 || m == 2) return 1'b1;
    if (m == 3) return p >= 2;
    if (m == 4 || m == 5) return p < 2;
    return 1'b0;
  endfunction

  task automatic pulse3(input int sel, input int width, input int exp, input string tag);
    wr(2'd3, 8'(sel));
    pin[3] = 1'b0;
    cyc(200);
    strobe(4'b1000);
    pin[3] = 1'b1;
    cyc(width);
    pin[3] = 1'b0;
    cyc(200);
    check(tag, pend[3], exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check("R12 pend", pend, 0);
    check("R12 req", req, 0);
    check("R12 vec", vec, 0);

    // R1 R2 R3 R4 R5: sweep every code on every pin
    wr(2'd2, 8'h0F);
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        bit lg;
        lg = legal(p, m);
        wr(2'(p / 2), 8'(m << (4 * (p % 2))));
        pin[p] = 1'b1; cyc(8);
        check($sformatf("R1/R2/R3/R4 rise p%0d m%0d", p, m), pend[p],
              lg && (m == 1 || m == 3 || m == 4));
        strobe(4'(1 << p)); cyc(1);
        check($sformatf("R3/R8 after clr high p%0d m%0d", p, m), pend[p], lg && m == 4);
        pin[p] = 1'b0; cyc(8);
        check($sformatf("R1/R2/R3/R4 fall p%0d m%0d", p, m), pend[p],
              lg && (m == 2 || m == 3 || m == 5));
        strobe(4'(1 << p)); cyc(1);
        check($sformatf("R3/R8 after clr low p%0d m%0d", p, m), pend[p], lg && m == 5);
      end
      wr(2'(p / 2), 8'h00);
    end

    // R6 R7: priority over all enable masks, every pin rising-edge pending
    wr(2'd0, 8'h11); wr(2'd1, 8'h11); wr(2'd3, 8'h00);
    pin = 4'hF; cyc(8);
    check("R1 all pending", pend, 4'hF);
    for (int e = 0; e < 16; e++) begin
      int idx;
      idx = -1;
      for (int k = 3; k >= 0; k--) if (e[k]) idx = k;
      wr(2'd2, 8'(e)); cyc(1);
      check($sformatf("R6 req en=%0h", e), req, idx >= 0);
      check($sformatf("R7 vec en=%0h", e), vec, idx >= 0 ? 3 + 8 * idx : 0);
    end

    // R8: single clear touches only its pin
    strobe(4'b0001); cyc(1);
    check("R8 single clear", pend, 4'b1110);
    check("R7 next winner", vec, 8'h0B);
    // R5: mode rewrite clears only its pair
    wr(2'd1, 8'h11); cyc(1);
    check("R5 rewrite pair", pend, 4'b0010);
    pin = 4'h0; cyc(8);
    strobe(4'hF);

    // R11: single-cycle pulses on pins 0..2
    for (int p = 0; p < 3; p++) begin
      cyc(4);
      pin[p] = 1'b1; cyc(1); pin[p] = 1'b0; cyc(8);
      check($sformatf("R11 one-cycle pin%0d", p), pend[p], 1);
    end

    // R9 R10: pin 3 filter windows
    pulse3(0, 1,   0, "R9 div1 w1");
    pulse3(0, 2,   1, "R9 div1 w2");
    pulse3(1, 12,  0, "R10 div16 w12");
    pulse3(1, 40,  1, "R10 div16 w40");
    pulse3(2, 48,  0, "R10 div64 w48");
    pulse3(2, 140, 1, "R10 div64 w140");
    pulse3(3, 48,  0, "R10 sel3 w48");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule